// File: doc/BRIEF.md
# I2C Master Start-Condition Sequencer

This block produces the Start condition that opens every transfer made by an I2C bus master. Software asks for a Start by setting a start-request bit in the command register. If both bus lines are seen high, the block times one baud interval from a reloadable down-counter. It then checks the bus again and pulls SDA low while SCL stays released. A second baud interval follows, after which the request bit clears, SDA stays held low and a completion interrupt is raised.

While a Start is pending, the block guards it. If SCL is seen low before SDA has been pulled down, the Start is aborted and a bus-collision flag is set. The same happens if a line is already low when the request is taken. A write to the transmit buffer during the Start is refused and sets a write-collision flag. Writes to the command-request bits are dropped, so no second command can be queued behind the Start.

Software reaches the block through a single-cycle write port with four registers. Address 0 holds the command bits. Address 1 holds the flags, which are cleared by writing zero. Address 2 holds the 7-bit reload value. Address 3 is the transmit buffer. Both bus lines are driven open-drain: an output-enable of 1 pulls the line low. The sampled inputs pass through a two-flop synchronizer before any decision is made on them.

Top module: `i2c_start_seq`

## Requirements
- R1: After a synchronous active-high reset, sda_oe, scl_oe, busy, done_irq and bcol_irq are 0, every flag is 0, cmd_req is 0 and tx_buf is 0.
- R2: A write of 1 to cmd_req bit 0 (address 0, data bit 0) makes busy read 1 from the cycle after the write edge. The sequence is launched only if synchronized SDA and SCL are both high.
- R3: With reload value R (address 2, bits 6:0) and a write edge at cycle E, sda_oe rises at E+R+2 and start_seen (flag bit 0) is set in that same cycle. scl_oe stays 0 throughout.
- R4: At E+2R+3 the Start completes. cmd_req bit 0 and busy return to 0, sda_oe stays 1, done_flag (flag bit 1) is set and done_irq is high for exactly one cycle.
- R5: A reload value of 0 gives one-clock baud intervals, so sda_oe rises at E+2 and completion falls at E+3.
- R6: If either synchronized line is low when the request is taken, the block does not launch. At E+1, bcol_flag (flag bit 2) is set, bcol_irq pulses for one cycle, cmd_req bit 0 and busy clear, and sda_oe stays 0.
- R7: If synchronized SCL goes low during the first baud interval, the Start aborts on the next edge. bcol_flag is set, bcol_irq pulses, busy clears and SDA is never pulled low.
- R8: A write to address 3 while busy sets wcol_flag (flag bit 3) and leaves tx_buf unchanged. The same write while idle loads tx_buf and leaves wcol_flag unchanged.
- R9: While busy, writes to address 0 leave cmd_req unchanged. While idle, such a write loads all five command bits.
- R10: A write to address 1 clears each flag whose data bit is 0 and leaves the flags whose data bit is 1 unchanged. A flag set event in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 command, 1 flags, 2 reload, 3 transmit buffer |
| wr_data | input | 8 | Register write data |
| sda_in | input | 1 | Sampled SDA level (asynchronous) |
| scl_in | input | 1 | Sampled SCL level (asynchronous) |
| sda_oe | output | 1 | 1 pulls SDA low |
| scl_oe | output | 1 | 1 pulls SCL low |
| busy | output | 1 | A Start request is pending or in progress |
| cmd_req | output | 5 | Command-request bits: 0 start, 1 restart, 2 stop, 3 receive, 4 acknowledge |
| tx_buf | output | 8 | Transmit buffer contents |
| start_seen | output | 1 | Sticky: Start condition placed on the bus |
| done_flag | output | 1 | Sticky: Start sequence completed |
| bcol_flag | output | 1 | Sticky: bus collision |
| wcol_flag | output | 1 | Sticky: write collision on the transmit buffer |
| done_irq | output | 1 | One-cycle completion pulse |
| bcol_irq | output | 1 | One-cycle bus-collision pulse |

## Verification
Register writes show their effects in the cycle after the write edge. These effects are busy, tx_buf, cmd_req, the flag updates and write collisions. The SDA pull-down comes R+2 cycles after the request edge and completion comes 2R+3 cycles after it. A collision at launch appears one cycle after the request edge. An SCL drop is seen by the sequencer two edges after it reaches the pin and takes effect on the third. The driver records the cycle number of each stimulus edge and queues every expected value tagged with the exact cycle in which it is due, including the cycles just before each change. The monitor compares only at those cycles, half a clock after the edge. Any item whose cycle has passed unchecked is reported as a failure.

// File: rtl/i2c_sc_pkg.sv
package i2c_sc_pkg;

  localparam int ADDR_W = 2;
  localparam int CMD_W  = 5;
  localparam int FLAG_W = 4;

  localparam logic [ADDR_W-1:0] A_CMD    = 2'd0;
  localparam logic [ADDR_W-1:0] A_FLAG   = 2'd1;
  localparam logic [ADDR_W-1:0] A_RELOAD = 2'd2;
  localparam logic [ADDR_W-1:0] A_TXB    = 2'd3;

  localparam int CMD_START = 0;

  localparam int FL_SEEN = 0;
  localparam int FL_DONE = 1;
  localparam int FL_BCOL = 2;
  localparam int FL_WCOL = 3;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_FIRST  = 2'd1,
    SEQ_SECOND = 2'd2
  } seq_state_t;

  // Clear-by-zero write, then set events take priority.
  function automatic logic [FLAG_W-1:0] merge_flags(
    input logic [FLAG_W-1:0] cur,
    input logic              wr,
    input logic [FLAG_W-1:0] keep,
    input logic [FLAG_W-1:0] set
  );
    return (wr ? (cur & keep) : cur) | set;
  endfunction

endpackage

// File: rtl/i2c_sc_sync.sv
module i2c_sc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  // Bus idles high, so the chain resets to ones.
  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/i2c_sc_baud.sv
module i2c_sc_baud #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             run,
  input  logic [CNT_W-1:0] reload,
  output logic             tick
);
  logic [CNT_W-1:0] count;

  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] c);
    return (c == '0) ? c : c - 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (load) count <= reload;
    else if (run)  count <= step_down(count);
  end

  assign tick = run && (count == '0);

  // R5
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !load && count != '0) |=> count == $past(count) - 1'b1);
endmodule

// File: rtl/i2c_sc_fsm.sv
module i2c_sc_fsm
  import i2c_sc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic sda_s,
  input  logic scl_s,
  input  logic tick,
  output logic load,
  output logic run,
  output logic ev_launch,
  output logic ev_sda_low,
  output logic ev_done,
  output logic ev_coll
);
  seq_state_t state, nxt;

  always_comb begin
    nxt        = state;
    load       = 1'b0;
    run        = 1'b0;
    ev_launch  = 1'b0;
    ev_sda_low = 1'b0;
    ev_done    = 1'b0;
    ev_coll    = 1'b0;
    case (state)
      SEQ_IDLE: begin
        if (req) begin
          if (sda_s && scl_s) begin
            ev_launch = 1'b1;
            load      = 1'b1;
            nxt       = SEQ_FIRST;
          end else begin
            ev_coll = 1'b1;
          end
        end
      end
      SEQ_FIRST: begin
        run = 1'b1;
        if (!scl_s) begin
          ev_coll = 1'b1;
          nxt     = SEQ_IDLE;
        end else if (tick) begin
          if (sda_s) begin
            ev_sda_low = 1'b1;
            load       = 1'b1;
            nxt        = SEQ_SECOND;
          end else begin
            ev_coll = 1'b1;
            nxt     = SEQ_IDLE;
          end
        end
      end
      SEQ_SECOND: begin
        run = 1'b1;
        if (tick) begin
          ev_done = 1'b1;
          nxt     = SEQ_IDLE;
        end
      end
      default: nxt = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= SEQ_IDLE;
    else     state <= nxt;
  end

  // R4
  done_ends_chk: assert property (@(posedge clk) disable iff (rst)
    ev_done |=> state == SEQ_IDLE);

  // R3
  second_entry_chk: assert property (@(posedge clk) disable iff (rst)
    ev_sda_low |=> state == SEQ_SECOND);
endmodule

// File: rtl/i2c_start_seq.sv
module i2c_start_seq
  import i2c_sc_pkg::*;
#(
  parameter int RELOAD_W    = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sda_in,
  input  logic              scl_in,
  output logic              sda_oe,
  output logic              scl_oe,
  output logic              busy,
  output logic [4:0]        cmd_req,
  output logic [DATA_W-1:0] tx_buf,
  output logic              start_seen,
  output logic              done_flag,
  output logic              bcol_flag,
  output logic              wcol_flag,
  output logic              done_irq,
  output logic              bcol_irq
);
  localparam int N_LINES = 2;

  logic [N_LINES-1:0]  raw_lines, synced;
  logic                sda_s, scl_s;
  logic [CMD_W-1:0]    cmd_q;
  logic [RELOAD_W-1:0] reload_q;
  logic [DATA_W-1:0]   txb_q;
  logic [FLAG_W-1:0]   flags_q, flag_set;
  logic                sda_hold, done_irq_q, bcol_irq_q;
  logic                wr_cmd, wr_flag, wr_reload, wr_txb, start_active;
  logic                load, run, tick;
  logic                ev_launch, ev_sda_low, ev_done, ev_coll, ev_wcol;

  assign raw_lines = {scl_in, sda_in};
  for (genvar g = 0; g < N_LINES; g++) begin : g_sync
    i2c_sc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .d(raw_lines[g]), .q(synced[g])
    );
  end
  assign sda_s = synced[0];
  assign scl_s = synced[1];

  assign wr_cmd       = wr_en && (wr_addr == A_CMD);
  assign wr_flag      = wr_en && (wr_addr == A_FLAG);
  assign wr_reload    = wr_en && (wr_addr == A_RELOAD);
  assign wr_txb       = wr_en && (wr_addr == A_TXB);
  assign start_active = cmd_q[CMD_START];
  assign ev_wcol      = wr_txb && start_active;

  i2c_sc_baud #(.CNT_W(RELOAD_W)) u_baud (
    .clk(clk), .rst(rst), .load(load), .run(run), .reload(reload_q), .tick(tick)
  );

  i2c_sc_fsm u_fsm (
    .clk(clk), .rst(rst), .req(start_active), .sda_s(sda_s), .scl_s(scl_s),
    .tick(tick), .load(load), .run(run), .ev_launch(ev_launch),
    .ev_sda_low(ev_sda_low), .ev_done(ev_done), .ev_coll(ev_coll)
  );

  // Command bits: locked while a Start is pending; start bit cleared by hardware.
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0;
    end else begin
      if (ev_done || ev_coll) cmd_q[CMD_START] <= 1'b0;
      if (wr_cmd && !start_active) cmd_q <= wr_data[CMD_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            reload_q <= '0;
    else if (wr_reload) reload_q <= wr_data[RELOAD_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)                         txb_q <= '0;
    else if (wr_txb && !start_active) txb_q <= wr_data;
  end

  always_comb begin
    flag_set          = '0;
    flag_set[FL_SEEN] = ev_sda_low;
    flag_set[FL_DONE] = ev_done;
    flag_set[FL_BCOL] = ev_coll;
    flag_set[FL_WCOL] = ev_wcol;
  end

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= merge_flags(flags_q, wr_flag, wr_data[FLAG_W-1:0], flag_set);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sda_hold   <= 1'b0;
      done_irq_q <= 1'b0;
      bcol_irq_q <= 1'b0;
    end else begin
      if (ev_sda_low)   sda_hold <= 1'b1;
      else if (ev_coll) sda_hold <= 1'b0;
      done_irq_q <= ev_done;
      bcol_irq_q <= ev_coll;
    end
  end

  assign sda_oe     = sda_hold;
  assign scl_oe     = 1'b0;
  assign busy       = start_active;
  assign cmd_req    = cmd_q;
  assign tx_buf     = txb_q;
  assign start_seen = flags_q[FL_SEEN];
  assign done_flag  = flags_q[FL_DONE];
  assign bcol_flag  = flags_q[FL_BCOL];
  assign wcol_flag  = flags_q[FL_WCOL];
  assign done_irq   = done_irq_q;
  assign bcol_irq   = bcol_irq_q;

  // R2
  launch_bus_chk: assert property (@(posedge clk) disable iff (rst)
    ev_launch |=> busy && !sda_oe);

  // R3
  sda_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> start_seen);

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_irq |=> !done_irq);

  // R6
  coll_release_chk: assert property (@(posedge clk) disable iff (rst)
    bcol_irq |-> (!sda_oe && !busy && bcol_flag));

  // R8
  wcol_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (start_active && wr_txb) |=> (wcol_flag && $stable(tx_buf)));

  // R9
  cmd_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (start_active && wr_cmd) |=> cmd_req[4:1] == $past(cmd_req[4:1]));
endmodule

// File: tb/test_i2c_start_seq.sv
module test_i2c_start_seq;
  localparam int S_SDA = 0, S_SCL = 1, S_BUSY = 2, S_SEEN = 3, S_DONE = 4,
                 S_DIRQ = 5, S_BCOL = 6, S_BIRQ = 7, S_WCOL = 8, S_TXB = 9, S_CMD = 10;

  logic       clk = 1'b0, rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       sda_in = 1'b1, scl_in = 1'b1;
  logic       sda_oe, scl_oe, busy, start_seen, done_flag, bcol_flag, wcol_flag;
  logic       done_irq, bcol_irq;
  logic [4:0] cmd_req;
  logic [7:0] tx_buf;

  i2c_start_seq i_i2c_start_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sda_in(sda_in), .scl_in(scl_in), .sda_oe(sda_oe), .scl_oe(scl_oe),
    .busy(busy), .cmd_req(cmd_req), .tx_buf(tx_buf), .start_seen(start_seen),
    .done_flag(done_flag), .bcol_flag(bcol_flag), .wcol_flag(wcol_flag),
    .done_irq(done_irq), .bcol_irq(bcol_irq)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int at; int sig; int val; string req; } exp_t;
  exp_t sb[$];
  int n_chk = 0, n_fail = 0;

  function automatic int observe(input int s);
    case (s)
      S_SDA:  return int'(sda_oe);
      S_SCL:  return int'(scl_oe);
      S_BUSY: return int'(busy);
      S_SEEN: return int'(start_seen);
      S_DONE: return int'(done_flag);
      S_DIRQ: return int'(done_irq);
      S_BCOL: return int'(bcol_flag);
      S_BIRQ: return int'(bcol_irq);
      S_WCOL: return int'(wcol_flag);
      S_TXB:  return int'(tx_buf);
      default: return int'(cmd_req);
    endcase
  endfunction

  // Driver side: queue an expected value for a given cycle, kept sorted.
  task automatic expect_at(input int at, input int sig, input int val, input string req);
    exp_t e;
    int pos;
    e.at = at; e.sig = sig; e.val = val; e.req = req;
    pos = sb.size();
    for (int i = 0; i < sb.size(); i++) begin
      if (sb[i].at > at) begin pos = i; break; end
    end
    sb.insert(pos, e);
  endtask

  // Monitor: compare each item half a clock after its edge.
  initial forever begin
    @(negedge clk);
    #1;
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      exp_t e;
      int got;
      e = sb.pop_front();
      n_chk++;
      got = observe(e.sig);
      if (e.at < cyc) begin
        n_fail++;
        $display("FAIL %s sig%0d missed at cycle %0d: actual=none expected=%0d", e.req, e.sig, e.at, e.val);
      end else if (got != e.val) begin
        n_fail++;
        $display("FAIL %s sig%0d cycle %0d: actual=%0d expected=%0d", e.req, e.sig, e.at, got, e.val);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d, output int e);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    e = cyc;
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int e, e0;
    @(negedge clk);
    do_reset();
    // R1 reset state
    expect_at(cyc, S_SDA, 0, "R1");  expect_at(cyc, S_SCL, 0, "R1");
    expect_at(cyc, S_BUSY, 0, "R1"); expect_at(cyc, S_SEEN, 0, "R1");
    expect_at(cyc, S_DONE, 0, "R1"); expect_at(cyc, S_BCOL, 0, "R1");
    expect_at(cyc, S_WCOL, 0, "R1"); expect_at(cyc, S_DIRQ, 0, "R1");
    expect_at(cyc, S_BIRQ, 0, "R1"); expect_at(cyc, S_CMD, 0, "R1");
    expect_at(cyc, S_TXB, 0, "R1");
    @(negedge clk);

    // Normal Start, reload 10
    wr(2'd2, 8'd10, e);
    wr(2'd0, 8'h01, e0);
    expect_at(e0, S_BUSY, 1, "R2");
    expect_at(e0 + 11, S_SDA, 0, "R3");  expect_at(e0 + 12, S_SDA, 1, "R3");
    expect_at(e0 + 11, S_SEEN, 0, "R3"); expect_at(e0 + 12, S_SEEN, 1, "R3");
    expect_at(e0 + 12, S_SCL, 0, "R3");
    expect_at(e0 + 22, S_BUSY, 1, "R4"); expect_at(e0 + 23, S_BUSY, 0, "R4");
    expect_at(e0 + 22, S_DIRQ, 0, "R4"); expect_at(e0 + 23, S_DIRQ, 1, "R4");
    expect_at(e0 + 24, S_DIRQ, 0, "R4"); expect_at(e0 + 23, S_DONE, 1, "R4");
    expect_at(e0 + 23, S_CMD, 0, "R4");  expect_at(e0 + 30, S_SDA, 1, "R4");
    expect_at(e0 + 30, S_BCOL, 0, "R4");
    wr(2'd3, 8'h5A, e);
    expect_at(e, S_WCOL, 1, "R8"); expect_at(e, S_TXB, 0, "R8");
    wr(2'd0, 8'h1C, e);
    expect_at(e, S_CMD, 1, "R9");
    while (cyc < e0 + 31) @(negedge clk);

    wr(2'd3, 8'hA5, e);
    expect_at(e, S_TXB, 8'hA5, "R8"); expect_at(e, S_WCOL, 1, "R8");
    wr(2'd0, 8'h04, e);
    expect_at(e, S_CMD, 4, "R9"); expect_at(e, S_BUSY, 0, "R9");
    wr(2'd1, 8'hF7, e);
    expect_at(e, S_WCOL, 0, "R10"); expect_at(e, S_DONE, 1, "R10");
    expect_at(e, S_SEEN, 1, "R10");
    wr(2'd1, 8'h00, e);
    expect_at(e, S_DONE, 0, "R10"); expect_at(e, S_SEEN, 0, "R10");
    repeat (2) @(negedge clk);

    // Reload 0
    do_reset();
    wr(2'd0, 8'h01, e0);
    expect_at(e0 + 1, S_SDA, 0, "R5");  expect_at(e0 + 2, S_SDA, 1, "R5");
    expect_at(e0 + 2, S_BUSY, 1, "R5"); expect_at(e0 + 3, S_BUSY, 0, "R5");
    expect_at(e0 + 3, S_DIRQ, 1, "R5");
    repeat (6) @(negedge clk);

    // SCL low at request
    do_reset();
    scl_in = 1'b0;
    repeat (3) @(negedge clk);
    wr(2'd0, 8'h01, e0);
    expect_at(e0, S_BUSY, 1, "R6");
    expect_at(e0 + 1, S_BIRQ, 1, "R6"); expect_at(e0 + 2, S_BIRQ, 0, "R6");
    expect_at(e0 + 1, S_BCOL, 1, "R6"); expect_at(e0 + 1, S_BUSY, 0, "R6");
    expect_at(e0 + 1, S_CMD, 0, "R6");  expect_at(e0 + 1, S_SDA, 0, "R6");
    expect_at(e0 + 12, S_SEEN, 0, "R6");
    repeat (14) @(negedge clk);
    scl_in = 1'b1;

    // SDA low at request
    do_reset();
    sda_in = 1'b0;
    repeat (3) @(negedge clk);
    wr(2'd0, 8'h01, e0);
    expect_at(e0 + 1, S_BCOL, 1, "R6"); expect_at(e0 + 1, S_BUSY, 0, "R6");
    repeat (4) @(negedge clk);
    sda_in = 1'b1;

    // SCL drops during first interval
    do_reset();
    repeat (3) @(negedge clk);
    wr(2'd2, 8'd10, e);
    wr(2'd0, 8'h01, e0);
    repeat (2) @(negedge clk);
    scl_in = 1'b0;
    expect_at(e0 + 4, S_BUSY, 1, "R7");
    expect_at(e0 + 4, S_BIRQ, 0, "R7"); expect_at(e0 + 5, S_BIRQ, 1, "R7");
    expect_at(e0 + 5, S_BUSY, 0, "R7"); expect_at(e0 + 5, S_BCOL, 1, "R7");
    expect_at(e0 + 12, S_SDA, 0, "R7"); expect_at(e0 + 12, S_SEEN, 0, "R7");
    while (cyc < e0 + 14) @(negedge clk);
    scl_in = 1'b1;

    while (sb.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule